// File: doc/BRIEF.md
# Capture Memory Sequencer with Nibble Readout

This block owns a byte-wide sample memory and the single address counter that walks it. A host issues a clear; from then on the block stores one converter byte at each sample-enable cycle, at consecutive addresses starting from zero. The host takes no part in this. When the last location has been written, the counter wraps to zero, writing stops and a done flag rises.

Once done is high, the memory becomes a slow readout port. Each host step pulse moves the shared address forward by one. The byte at the current address is presented on a 4-bit output, one half at a time, and a select line picks which half. A fast capture can therefore be drained by a host whose link is much slower and narrower than the converter.

The capacity is 2**ADDR_W bytes. The full-size system uses ADDR_W = 15, which gives 32768 samples. The default is kept smaller so the design elaborates quickly.

Top module: `cap_seq_top`

## Requirements
- R1: After rst_n is released, done is 0 and stays 0 while sample enables arrive, until the first host_clr.
- R2: A host_clr cycle sets the address to 0 and starts a capture. done is 0 from the next clock edge onward, in every phase.
- R3: During capture, each cycle with smp_en = 1 stores adc_data at the current address and then advances the address by one. Cycles with smp_en = 0 store nothing and leave the address unchanged.
- R4: Exactly 2**ADDR_W samples are stored per capture. done rises at the clock edge that accepts the last sample, when the address wraps from all-ones to 0.
- R5: Readout starts at address 0. The byte stored by the first sample after the clear is on the output from the second clock edge after done rises.
- R6: In readout, each cycle with host_step = 1 advances the address by one. The new byte is valid from the second clock edge after the step cycle.
- R7: nib_hi = 0 puts bits 3:0 of the current byte on nib_out, and nib_hi = 1 puts bits 7:4 there. The select acts without a clock edge.
- R8: host_step has no effect while done is 0. The stored sample sequence is the same whether steps arrive during capture or not.
- R9: smp_en has no effect while done is 1. Stored bytes are not overwritten.
- R10: In readout, stepping past the last address returns to address 0, and done stays 1.
- R11: host_clr takes priority over host_step and smp_en in the same cycle. A clear during capture or during readout restarts capture at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| adc_data | input | 8 | Converter byte to store |
| smp_en | input | 1 | Sample strobe, one byte per high cycle |
| host_clr | input | 1 | Host clear: zero the address and start a capture |
| host_step | input | 1 | Host step: advance the readout address |
| nib_hi | input | 1 | Half select: 0 gives the low four bits, 1 gives the high four bits |
| nib_out | output | 4 | Selected half of the current byte |
| done | output | 1 | High once the memory is full, until the next clear |

## Verification
A wrong count in the address counter shows up at the ports in two ways. done rises earlier or later than the edge that accepts sample 2**ADDR_W, and this is visible within one cycle. Readout also returns bytes shifted against the order they were stored, which is visible at the first byte read. A phase error, such as a step accepted during capture or a write accepted after done, does not show until readout. There the affected bytes come back as gaps, repeats or overwritten values. The bench therefore checks done on every cycle and reads back every location, plus the wrap, after each capture.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_READOUT = 2'd2
  } phase_t;
endpackage

// File: rtl/cap_addr_ctr.sv
// Shared write/read address counter; clear has priority over advance.
module cap_addr_ctr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] addr_q,
  output logic          at_last
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  logic [AW-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr)      addr_d = '0;
    else if (adv) addr_d = addr_q + ADDR_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign at_last = (addr_q == {AW{1'b1}});
endmodule

// File: rtl/cap_phase_ctl.sv
// Phase sequencer: idle -> capture -> readout, restart on host clear.
module cap_phase_ctl (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_clr,
  input  logic            host_step,
  input  logic            smp_en,
  input  logic            at_last,
  output cap_pkg::phase_t phase_q,
  output logic            wr_en,
  output logic            adv
);
  import cap_pkg::*;

  phase_t phase_d;

  always_comb begin
    wr_en   = 1'b0;
    adv     = 1'b0;
    phase_d = phase_q;
    if (host_clr) begin
      phase_d = PH_CAPTURE;
    end else begin
      case (phase_q)
        PH_CAPTURE: begin
          if (smp_en) begin
            wr_en = 1'b1;
            adv   = 1'b1;
            if (at_last) phase_d = PH_READOUT;
          end
        end
        PH_READOUT: begin
          if (host_step) adv = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/cap_sample_ram.sv
// Synchronous single-port array: a write cycle or a registered read.
module cap_sample_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else    rdata     <= mem[addr];
  end
endmodule

// File: rtl/cap_nibble_mux.sv
// Two-way half-word selector for the narrow host port.
module cap_nibble_mux #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   din,
  input  logic            sel_hi,
  output logic [DW/2-1:0] dout
);
  localparam int HW = DW / 2;

  assign dout = sel_hi ? din[DW-1:HW] : din[HW-1:0];
endmodule

// File: rtl/cap_seq_top.sv
module cap_seq_top #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] adc_data,
  input  logic              smp_en,
  input  logic              host_clr,
  input  logic              host_step,
  input  logic              nib_hi,
  output logic [DATA_W/2-1:0] nib_out,
  output logic              done
);
  import cap_pkg::*;

  phase_t            phase_q;
  logic              wr_en;
  logic              adv;
  logic              at_last;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_q;

  cap_phase_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_clr  (host_clr),
    .host_step (host_step),
    .smp_en    (smp_en),
    .at_last   (at_last),
    .phase_q   (phase_q),
    .wr_en     (wr_en),
    .adv       (adv)
  );

  cap_addr_ctr #(.AW(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (host_clr),
    .adv     (adv),
    .addr_q  (addr_q),
    .at_last (at_last)
  );

  cap_sample_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .addr  (addr_q),
    .wdata (adc_data),
    .rdata (rd_q)
  );

  cap_nibble_mux #(.DW(DATA_W)) u_mux (
    .din    (rd_q),
    .sel_hi (nib_hi),
    .dout   (nib_out)
  );

  assign done = (phase_q == PH_READOUT);
endmodule

// File: rtl/cap_seq_chk.sv
module cap_seq_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_clr,
  input logic              host_step,
  input logic              smp_en,
  input logic              done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr
);
  localparam int            DEPTH    = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= '0;
    else if (host_clr) seen_q <= '0;
    else if (wr_en)    seen_q <= seen_q + 1'b1;
  end

  // R2: a clear drops done at the next edge
  p_clr_drops_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr |=> !done);

  // R4: done rises only after exactly DEPTH accepted samples, at address 0
  p_full_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (seen_q == (ADDR_W+1)'(DEPTH)) && (addr == '0));

  // R8: with no sample and no clear, the address holds before done
  p_step_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !smp_en && !host_clr) |=> $stable(addr));

  // R6: a step in readout moves the address by exactly one
  p_step_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && host_step && !host_clr) |=> (addr == $past(addr) + ADDR_ONE));

  // R9: the memory is never written once done is high
  p_no_write_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !done);

  // R10: done persists until a clear
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !host_clr) |=> done);
endmodule

bind cap_seq_top cap_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_clr  (host_clr),
  .host_step (host_step),
  .smp_en    (smp_en),
  .done      (done),
  .wr_en     (wr_en),
  .addr      (addr_q)
);

// File: tb/sim_cap_seq_top.sv
module sim_cap_seq_top;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;

  logic       clk;
  logic       rst_n;
  logic [7:0] adc_data;
  logic       smp_en;
  logic       host_clr;
  logic       host_step;
  logic       nib_hi;
  logic [3:0] nib_out;
  logic       done;

  cap_seq_top #(.ADDR_W(AW), .DATA_W(8)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_data  (adc_data),
    .smp_en    (smp_en),
    .host_clr  (host_clr),
    .host_step (host_step),
    .nib_hi    (nib_hi),
    .nib_out   (nib_out),
    .done      (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  n_chk;
  int  n_bad;
  bit  finished;

  logic [7:0] model [DEPTH];
  int  exp_cnt;
  int  exp_addr;
  bit  exp_done;
  bit  capturing;

  function automatic logic [3:0] exp_nib(logic [7:0] b, bit hi);
    return hi ? b[7:4] : b[3:0];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // One clock cycle: drive at negedge, update model, check done afterwards.
  task automatic cyc(bit en, logic [7:0] d, bit step, bit clr, string req);
    smp_en = en; adc_data = d; host_step = step; host_clr = clr;
    if (clr) begin
      exp_cnt = 0; exp_addr = 0; exp_done = 1'b0; capturing = 1'b1;
    end else if (capturing && !exp_done && en) begin
      model[exp_cnt] = d;
      exp_cnt++;
      if (exp_cnt == DEPTH) begin
        exp_done = 1'b1; exp_addr = 0;
      end
    end else if (exp_done && step) begin
      exp_addr = (exp_addr + 1) % DEPTH;
    end
    @(posedge clk);
    @(negedge clk);
    chk(done == exp_done, req, int'(done), int'(exp_done));
  endtask

  // Random capture until full; random steps check R8.
  task automatic capture(int en_pct);
    while (!exp_done) begin
      cyc(($urandom % 100) < en_pct, 8'($urandom), ($urandom % 3) == 0, 1'b0, "R4");
    end
  endtask

  // Read n bytes: one settle cycle with stray sample enables (R9), check both halves, step.
  task automatic readout(int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b1, 8'($urandom), 1'b0, 1'b0, "R10");
      nib_hi = 1'b0; #1;
      chk(nib_out == exp_nib(model[exp_addr], 1'b0),
          (i == 0) ? "R5" : ((i >= DEPTH) ? "R10" : "R6"),
          int'(nib_out), int'(exp_nib(model[exp_addr], 1'b0)));
      nib_hi = 1'b1; #1;
      chk(nib_out == exp_nib(model[exp_addr], 1'b1), "R7",
          int'(nib_out), int'(exp_nib(model[exp_addr], 1'b1)));
      cyc(($urandom % 2) == 0, 8'($urandom), 1'b1, 1'b0, "R9");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    n_chk = 0; n_bad = 0; finished = 1'b0;
    exp_cnt = 0; exp_addr = 0; exp_done = 1'b0; capturing = 1'b0;
    smp_en = 1'b0; adc_data = '0; host_clr = 1'b0; host_step = 1'b0; nib_hi = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", int'(done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: sample enables before any clear never complete a capture
    for (int i = 0; i < DEPTH + 8; i++) cyc(1'b1, 8'($urandom), 1'b0, 1'b0, "R1");

    // R2, R3, R4, R8: first capture with random gaps and stray steps
    cyc(1'b0, 8'h00, 1'b0, 1'b1, "R2");
    capture(55);
    // R5, R6, R7, R9, R10: read every byte plus two past the wrap
    readout(DEPTH + 2);

    // R11: clear together with a step during readout restarts at address 0
    cyc(1'b1, 8'hA5, 1'b1, 1'b1, "R11");
    for (int i = 0; i < 100; i++) cyc(1'b1, 8'(i * 7 + 3), 1'b1, 1'b0, "R3");
    // R11: clear during capture, with enable and step in the same cycle
    cyc(1'b1, 8'h3C, 1'b1, 1'b1, "R11");
    // R3: every-cycle enables with a walking data pattern, no steps
    while (!exp_done) cyc(1'b1, 8'(exp_cnt ^ (exp_cnt >> 3)), 1'b0, 1'b0, "R3");
    readout(DEPTH + 1);

    // R2: a clear drops done; then a sparse capture
    cyc(1'b0, 8'h00, 1'b0, 1'b1, "R2");
    capture(20);
    readout(16);

    summary();
  end
endmodule